// File: doc/BRIEF.md
# Write-Completion Status Poller

After a program or erase command has been sent to a parallel NOR-style flash, the host has to wait for the internal write to finish. This block does that waiting. It reads one location over and over through a single-request read port until the status bits in the returned byte show that the operation is over. It can watch one of two status bits. In data-polling mode it watches the top data bit, which reads as the inverse of the expected value (program) or as 0 (erase) while the device is busy. In toggle mode it watches the next bit down, which flips on every read while the device is busy.

The full byte on the bus can be wrong for a short time after the status bit settles. When completion is seen, the poller therefore lets a programmable number of idle cycles pass and then reads the whole byte and compares it with the expected value. A mismatch at that point is not accepted on one read. Two further reads are taken, and the operation is judged good only if both of them match. A programmable cycle timeout ends a poll that never completes. The result comes out as a single-cycle `done` or `fail` pulse, and the block then returns to idle.

Top module: `wcs_poller`

## Requirements
- R1: After reset, `done`, `fail` and `rd_req` are all low and the block is idle.
- R2: The block has at most one read outstanding. `rd_req` rises in the cycle after a start is accepted. It stays high until a cycle in which `rd_valid` is high, and it can only drop early when the operation ends. `rd_data` is used only in cycles where both `rd_req` and `rd_valid` are high.
- R3: With `poll_toggle`=0, a polling read shows completion when bit DATA_W-1 equals bit DATA_W-1 of `exp_data` (for `op_erase`=0, program) or equals 1 (for `op_erase`=1, erase).
- R4: With `poll_toggle`=1, a polling read shows completion when bit DATA_W-2 equals the same bit of the previous read in the same run. The first read of a run never shows completion.
- R5: After the read that shows completion, `rd_req` stays low for exactly `settle_limit`+1 cycles. Then the verify read is requested.
- R6: If the verify read returns a byte equal to the expected byte, `done` is high for one cycle, starting in the cycle after that read is sampled.
- R7: If the verify read mismatches, two more reads are taken. `done` follows only if both match. The first of them that mismatches causes `fail` in the next cycle.
- R8: Let a start be accepted at clock edge k. If no result has been reached earlier, `fail` is high in the cycle that follows edge k+`tmo_limit`+1.
- R9: Each run produces exactly one one-cycle pulse, either `done` or `fail`, never both together. If completion and timeout fall in the same cycle, `done` wins. The block is idle in the pulse cycle.
- R10: A `start` while the block is busy is ignored. The mode, the operation type and the expected byte are captured when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted when idle) |
| poll_toggle | input | 1 | 0 = data-polling bit, 1 = toggling bit |
| op_erase | input | 1 | 0 = program, 1 = erase |
| exp_data | input | DATA_W | Expected byte at the polled location |
| tmo_limit | input | TMO_W | Timeout in cycles |
| settle_limit | input | SET_W | Idle cycles before the verify read, minus one |
| rd_req | output | 1 | Read request toward the memory |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | DATA_W | Read data |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
The two decisions that can fall in one cycle are a passing verify or confirm read and the timeout reaching its limit. The bench repeats a fixed program poll while it sweeps `tmo_limit` across the cycle in which the verify read is sampled. On each sweep it checks that exactly one pulse appears. At the limit that equals the verify cycle it checks that `done` wins, and one cycle earlier it checks that `fail` is raised. A behavioural model of the same rules is stepped on every clock, so every sweep point is also compared cycle by cycle.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_POLL   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_CHECK  = 2'd3
  } wcs_state_e;

  typedef enum logic {
    MODE_DPOLL  = 1'b0,
    MODE_TOGGLE = 1'b1
  } wcs_mode_e;

  // status bit comparison for inverted-data polling
  function automatic logic dpoll_done(input logic erase, input logic exp_msb,
                                      input logic got_msb);
    return erase ? got_msb : (got_msb == exp_msb);
  endfunction

  // toggling bit has stopped when two reads in a row agree
  function automatic logic toggle_done(input logic prev_vld, input logic prev_bit,
                                       input logic got_bit);
    return prev_vld && (prev_bit == got_bit);
  endfunction

endpackage

// File: rtl/wcs_judge.sv
module wcs_judge
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  wcs_mode_e         mode,
  input  logic              erase,
  input  logic [DATA_W-1:0] exp_q,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              prev_vld,
  input  logic              prev_bit,
  output logic              complete,
  output logic              byte_match
);
  localparam int DP_BIT = DATA_W - 1;
  localparam int TG_BIT = DATA_W - 2;

  always_comb begin
    if (mode == MODE_TOGGLE)
      complete = toggle_done(prev_vld, prev_bit, rd_data[TG_BIT]);
    else
      complete = dpoll_done(erase, exp_q[DP_BIT], rd_data[DP_BIT]);
    byte_match = (rd_data == exp_q);
  end
endmodule

// File: rtl/wcs_cycle_cnt.sv
module wcs_cycle_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         reached
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (run && (cnt != CNT_MAX))
      cnt <= cnt + 1'b1;
  end

  assign reached = run && (cnt >= limit);
endmodule

// File: rtl/wcs_poller.sv
module wcs_poller
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 16,
  parameter int SET_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              poll_toggle,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [SET_W-1:0]  settle_limit,
  output logic              rd_req,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              fail
);
  localparam int TG_BIT = DATA_W - 2;
  localparam int CHK_W  = 2;

  wcs_state_e        st, st_nx;
  wcs_mode_e         mode_q;
  logic              erase_q;
  logic [DATA_W-1:0] exp_q;
  logic              prev_vld, prev_bit;
  logic [CHK_W-1:0]  chk_idx;
  logic              done_q, fail_q;

  // named internal events
  logic busy, accept, poll_hit, settle_exp, tmo_hit;
  logic chk_ok, chk_bad, done_now, reject, fail_now;
  logic complete, byte_match;

  assign busy   = (st != ST_IDLE);
  assign accept = (st == ST_IDLE) && start;
  assign rd_req = (st == ST_POLL) || (st == ST_CHECK);

  wcs_judge #(.DATA_W(DATA_W)) u_judge (
    .mode       (mode_q),
    .erase      (erase_q),
    .exp_q      (exp_q),
    .rd_data    (rd_data),
    .prev_vld   (prev_vld),
    .prev_bit   (prev_bit),
    .complete   (complete),
    .byte_match (byte_match)
  );

  wcs_cycle_cnt #(.W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .run     (busy),
    .limit   (tmo_limit),
    .reached (tmo_hit)
  );

  wcs_cycle_cnt #(.W(SET_W)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (poll_hit),
    .run     (st == ST_SETTLE),
    .limit   (settle_limit),
    .reached (settle_exp)
  );

  assign poll_hit = (st == ST_POLL) && rd_valid && complete;
  assign chk_ok   = (st == ST_CHECK) && rd_valid && byte_match;
  assign chk_bad  = (st == ST_CHECK) && rd_valid && !byte_match;
  // a match on the first confirm read only advances; verify and last confirm finish
  assign done_now = chk_ok && (chk_idx != 2'd1);
  assign reject   = chk_bad && (chk_idx != 2'd0);
  assign fail_now = reject || (tmo_hit && !done_now);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (start)      st_nx = ST_POLL;
      ST_POLL:   if (poll_hit)   st_nx = ST_SETTLE;
      ST_SETTLE: if (settle_exp) st_nx = ST_CHECK;
      ST_CHECK:  st_nx = ST_CHECK;
      default:   st_nx = ST_IDLE;
    endcase
    if (done_now || fail_now) st_nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      mode_q   <= MODE_DPOLL;
      erase_q  <= 1'b0;
      exp_q    <= '0;
      prev_vld <= 1'b0;
      prev_bit <= 1'b0;
      chk_idx  <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= done_now;
      fail_q <= fail_now;
      if (accept) begin
        mode_q   <= poll_toggle ? MODE_TOGGLE : MODE_DPOLL;
        erase_q  <= op_erase;
        exp_q    <= exp_data;
        prev_vld <= 1'b0;
      end
      if ((st == ST_POLL) && rd_valid) begin
        prev_vld <= 1'b1;
        prev_bit <= rd_data[TG_BIT];
      end
      if (st == ST_SETTLE)
        chk_idx <= '0;
      else if ((st == ST_CHECK) && rd_valid)
        chk_idx <= chk_idx + 1'b1;
    end
  end

  assign done = done_q;
  assign fail = fail_q;
endmodule

// File: rtl/wcs_poller_chk.sv
module wcs_poller_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic rd_valid,
  input logic done,
  input logic fail,
  input logic poll_hit,
  input logic done_now,
  input logic reject,
  input logic tmo_hit
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid && !tmo_hit) |=> rd_req);

  // R9
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  idle_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !rd_req);

  // R5
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |=> !rd_req);

  // R8
  tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !done_now) |=> fail);

  // R7
  reject_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (fail && !done));

  // R6
  verify_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_now |=> (done && !fail));
endmodule

bind wcs_poller wcs_poller_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .done     (done),
  .fail     (fail),
  .poll_hit (poll_hit),
  .done_now (done_now),
  .reject   (reject),
  .tmo_hit  (tmo_hit)
);

// File: tb/wcs_poller_tb_top.sv
`timescale 1ns/1ps
module wcs_poller_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        poll_toggle = 1'b0;
  logic        op_erase = 1'b0;
  logic [7:0]  exp_data = 8'h00;
  logic [15:0] tmo_limit = 16'd5000;
  logic [7:0]  settle_limit = 8'd2;
  logic        rd_req;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        done, fail;

  always #10 clk = ~clk;

  wcs_poller dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_toggle(poll_toggle),
    .op_erase(op_erase), .exp_data(exp_data), .tmo_limit(tmo_limit),
    .settle_limit(settle_limit), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .fail(fail)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // ---------------- flash read model ----------------
  int         busy_left, post_idx, bad_mask, reads, wait_cnt;
  logic       tog;
  logic [7:0] mem_exp;
  bit         mem_erase;

  function automatic logic [7:0] flash_byte();
    logic [7:0] b;
    bit bad;
    if (busy_left > 0) begin
      busy_left--;
      b = {(mem_erase ? 1'b0 : ~mem_exp[7]), tog, mem_exp[5:0] ^ 6'h2A};
      tog = ~tog;
    end else begin
      bad = (post_idx < 32) && bad_mask[post_idx];
      post_idx++;
      b = bad ? {(mem_erase ? 1'b1 : mem_exp[7]), mem_exp[6], mem_exp[5:0] ^ 6'h15}
              : mem_exp;
    end
    return b;
  endfunction

  // ---------------- behavioural reference ----------------
  int         m_phase = 0, m_elapsed = 0, m_settle = 0, m_conf = 0, m_prev = -1;
  bit         m_toggle, m_erase;
  logic [7:0] m_exp;
  bit         e_done = 0, e_fail = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_elapsed = 0; e_done = 0; e_fail = 0;
    end else begin
      bit fin, rej, hit, was_busy, okc;
      fin = 0; rej = 0;
      was_busy = (m_phase != 0);
      hit = was_busy && (m_elapsed >= int'(tmo_limit));
      case (m_phase)
        0: if (start) begin
             m_phase = 1; m_elapsed = 0; m_toggle = poll_toggle;
             m_erase = op_erase; m_exp = exp_data; m_prev = -1;
           end
        1: if (rd_valid) begin
             if (m_toggle) okc = (m_prev >= 0) && (m_prev == int'(rd_data[6]));
             else okc = m_erase ? (rd_data[7] == 1'b1) : (rd_data[7] == m_exp[7]);
             m_prev = int'(rd_data[6]);
             if (okc) begin m_phase = 2; m_settle = 0; end
           end
        2: if (m_settle >= int'(settle_limit)) begin m_phase = 3; m_conf = 0; end
           else m_settle++;
        3: if (rd_valid) begin
             if (rd_data == m_exp) begin
               if (m_conf == 1) m_conf = 2; else fin = 1;
             end else begin
               if (m_conf == 0) m_conf = 1; else rej = 1;
             end
           end
        default: m_phase = 0;
      endcase
      e_done = fin;
      e_fail = rej || (hit && !fin);
      if (e_done || e_fail) m_phase = 0;
      if (was_busy) m_elapsed++;
    end
  end

  // ---------------- per-clock compare, memory drive, gap tracking ----------------
  bit op_active = 0;
  int cur_gap = 0, max_gap_v = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(rd_req === ((m_phase == 1) || (m_phase == 3)), "R2 rd_req vs model",
            int'(rd_req), int'((m_phase == 1) || (m_phase == 3)));
      check(done === e_done, "R6 done vs model", int'(done), int'(e_done));
      check(fail === e_fail, "R8 fail vs model", int'(fail), int'(e_fail));
    end
    if (op_active && !done && !fail) begin
      if (!rd_req) cur_gap++; else cur_gap = 0;
      if (cur_gap > max_gap_v) max_gap_v = cur_gap;
    end
    if (!rst_n) begin
      rd_valid = 1'b0; wait_cnt = 0;
    end else if (rd_valid) begin
      rd_valid = 1'b0; wait_cnt = 0;
    end else if (rd_req) begin
      wait_cnt++;
      if (wait_cnt >= 2) begin
        rd_valid = 1'b1; rd_data = flash_byte(); reads++; wait_cnt = 0;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  task automatic run_op(input bit tgl, input bit ers, input logic [7:0] ex,
                        input int busy, input int mask, input int st, input int tmo,
                        input int stray, output bit got_done, output int nreads,
                        output int lat, output int gap);
    busy_left = busy; post_idx = 0; bad_mask = mask; tog = 1'b0;
    mem_exp = ex; mem_erase = ers; reads = 0; cur_gap = 0; max_gap_v = 0;
    settle_limit = 8'(st); tmo_limit = 16'(tmo);
    poll_toggle = tgl; op_erase = ers; exp_data = ex; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_active = 1; lat = 1;
    while (!(done || fail)) begin
      @(negedge clk);
      lat++;
      if (lat == stray) begin start = 1'b1; exp_data = 8'h00; end
      else start = 1'b0;
    end
    start = 1'b0;
    got_done = done;
    check(!(done && fail), "R9 both pulses", int'(done && fail), 0);
    nreads = reads; gap = max_gap_v; op_active = 0;
    @(negedge clk);
    check(!done && !fail, "R9 pulse width", int'(done || fail), 0);
    exp_data = ex;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got 0 expected 1 completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit d; int n, l, g;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!done && !fail && !rd_req, "R1 outputs after reset",
          int'({done, fail, rd_req}), 0);

    // R3 program, data polling
    run_op(0, 0, 8'hA5, 3, 0, 2, 5000, -1, d, n, l, g);
    check(d, "R3 program poll done", int'(d), 1);
    check(n == 5, "R3 program poll reads", n, 5);
    check(l == 17, "R6 done latency", l, 17);
    check(g == 3, "R5 settle gap (2)", g, 3);

    // R3 erase, data polling
    run_op(0, 1, 8'hFF, 2, 0, 1, 5000, -1, d, n, l, g);
    check(d, "R3 erase poll done", int'(d), 1);
    check(n == 4, "R3 erase poll reads", n, 4);

    // R4 toggle mode while busy
    run_op(1, 0, 8'h3C, 4, 0, 1, 5000, -1, d, n, l, g);
    check(d, "R4 toggle done", int'(d), 1);
    check(n == 7, "R4 toggle reads", n, 7);

    // R4 first read never completes
    run_op(1, 0, 8'h3C, 0, 0, 1, 5000, -1, d, n, l, g);
    check(d && n == 3, "R4 toggle first read ignored", n, 3);

    // R5 settle lengths
    run_op(0, 0, 8'h5A, 1, 0, 5, 5000, -1, d, n, l, g);
    check(g == 6, "R5 settle gap (5)", g, 6);
    run_op(0, 0, 8'h5A, 1, 0, 0, 5000, -1, d, n, l, g);
    check(g == 1, "R5 settle gap (0)", g, 1);

    // R7 confirm reads
    run_op(0, 0, 8'hA5, 2, 32'h2, 1, 5000, -1, d, n, l, g);
    check(d && n == 6, "R7 both confirms good -> done", int'(d), 1);
    run_op(0, 0, 8'hA5, 2, 32'h6, 1, 5000, -1, d, n, l, g);
    check(!d && n == 5, "R7 first confirm bad -> fail", int'(d), 0);
    run_op(0, 0, 8'hA5, 2, 32'hA, 1, 5000, -1, d, n, l, g);
    check(!d && n == 6, "R7 second confirm bad -> fail", int'(d), 0);

    // R8 timeout
    run_op(0, 0, 8'hA5, 1000, 0, 1, 40, -1, d, n, l, g);
    check(!d, "R8 timeout fails", int'(d), 0);
    check(l == 42, "R8 timeout latency", l, 42);

    // R10 start while busy ignored
    run_op(0, 0, 8'hA5, 3, 0, 2, 5000, 3, d, n, l, g);
    check(d && n == 5, "R10 stray start ignored", int'(d), 1);

    // R9 timeout vs verify in the same cycle
    run_op(0, 0, 8'hA5, 3, 0, 2, 15, -1, d, n, l, g);
    check(d, "R9 done wins on coincidence", int'(d), 1);
    run_op(0, 0, 8'hA5, 3, 0, 2, 14, -1, d, n, l, g);
    check(!d, "R9 timeout one cycle earlier", int'(d), 0);
    for (int lim = 8; lim <= 24; lim++) begin
      run_op(0, 0, 8'hA5, 3, 0, 2, lim, -1, d, n, l, g);
      check(d == (lim >= 15), "R9 sweep outcome", int'(d), int'(lim >= 15));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule